// File: doc/BRIEF.md
# Remote Terminal Command Legality and Status Word Unit

This unit holds the decision logic of a serial-bus remote terminal. It receives each command word that the line decoder has found valid and decides in one cycle whether the command is addressed to this terminal, whether it is a broadcast, and whether the host has marked it illegal. Legality comes from a 256-bit bitmap spread over sixteen 16-bit host registers. A set bit rejects the matching command.

The unit also builds the outgoing status word. It combines the terminal address, a Message Error flag, a Broadcast Command Received flag and the status bits that the host writes. An optional immediate-clear mode wipes the host status bits after each status word is sent. It makes an exception for the two mode codes that exist to fetch the previous status or the previous command: those responses leave the status bits in place. A broadcast-enable bit sets whether address 31 is treated as broadcast or as an ordinary terminal address.

The host register port has these locations:

| Address | Contents |
|---|---|
| 0–15 | Legality bitmap |
| 16 | Status control: bit 15 is the immediate-clear enable; bits 9:5 and 3:0 are the host status bits |
| 17 | Terminal configuration: bits 15:11 are the address, bit 10 is the address parity, bit 0 is the broadcast enable |

Reads are combinational. When a host write and an immediate clear fall in the same cycle, the host write wins.

Top module: `rt_legal_status`

## Requirements
- R1: The legality index is {broadcast, T/R bit 10, mode flag, 5-bit field}. The register selected is index[7:4] and the bit is index[3:0]. A bit of 1 gives `dec_legal`=0, and a bit of 0 gives `dec_legal`=1.
- R2: A command with subaddress (bits 9:5) equal to 0 or 31 is a mode code. Its 5-bit field is bits 4:0. For other commands the field is the subaddress. Both mode subaddresses map to the same legality bit.
- R3: An illegal command addressed to the terminal gives `dec_data_en`=0 and sets status bit 10 (Message Error). A legal non-spared command clears status bit 10 and gives `dec_data_en`=1.
- R4: With broadcast enabled (config bit 0 = 1), a command to address 31 gives `dec_bcast`=1 and `dec_respond`=0. If it is legal, it sets status bit 4.
- R5: With broadcast disabled, address 31 is an ordinary terminal address. A command to it is answered normally with `dec_bcast`=0.
- R6: The 5 address bits and the parity bit must hold an odd number of ones. Otherwise `cfg_err`=1, and commands to the terminal's own address are ignored (`dec_for_us`=0).
- R7: The status word is built as follows:
  - bits 15:11 are the configured address;
  - bits 9:5 and 3:0 come from the status control register;
  - writes to bits 14:10 and 4 of that register are discarded.
- R8: With immediate clear enabled, a `stat_sent` pulse clears the host status bits by the next cycle.
- R9: After a legal transmit command with mode code 2 or 18, a `stat_sent` pulse does not clear the host status bits. Such a command also leaves the Message Error and Broadcast Received bits unchanged.
- R10: A command to another address gives `dec_for_us`=0, `dec_respond`=0 and `dec_data_en`=0, and leaves the status word unchanged.
- R11: After reset the following hold:
  - the bitmap is zero;
  - the status control register reads 0;
  - the configuration register reads 16'h0401;
  - the status word is 0;
  - `cfg_err` is 0.
- R12: Every decision output is valid for one cycle, in the cycle after `cmd_valid` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| cmd_valid | input | 1 | A valid command word is present |
| cmd_word | input | 16 | Command word: address 15:11, T/R 10, subaddress 9:5, count/code 4:0 |
| stat_sent | input | 1 | The status word has been transmitted |
| dec_valid | output | 1 | Decision outputs are valid this cycle |
| dec_for_us | output | 1 | The command is addressed to this terminal or is a broadcast |
| dec_bcast | output | 1 | The command is a broadcast |
| dec_legal | output | 1 | The command is legal |
| dec_respond | output | 1 | A status response is due |
| dec_data_en | output | 1 | Data words may be handled |
| status_word | output | 16 | Outgoing status word |
| cfg_err | output | 1 | The address parity is wrong |

## Verification
The properties assume that `cmd_valid` comes as single-cycle strobes and that `stat_sent` arrives only after a command has been decided. The properties that relate a decision to the status word also assume that the host does not write the status or configuration registers in the cycle a command is sampled. The directed tasks drive every strobe for exactly one cycle on the falling edge. They keep host writes apart from command strobes and send `stat_sent` only after the decision outputs have been checked.

// File: rtl/rtls_pkg.sv
package rtls_pkg;
    localparam int WORD_W    = 16;
    localparam int FIELD_W   = 5;
    localparam int RA_W      = 5;
    localparam int HA_W      = 5;
    localparam int LEG_IDX_W = 3 + FIELD_W;
    localparam int LEG_BITS  = 2 ** LEG_IDX_W;
    localparam int LEG_REGS  = LEG_BITS / WORD_W;
    localparam int BIT_SEL_W = $clog2(WORD_W);
    localparam int REG_SEL_W = $clog2(LEG_REGS);

    localparam logic [HA_W-1:0]    HA_LEG_END = HA_W'(LEG_REGS);
    localparam logic [HA_W-1:0]    HA_STATUS  = HA_W'(16);
    localparam logic [HA_W-1:0]    HA_CONFIG  = HA_W'(17);
    localparam logic [RA_W-1:0]    BCAST_ADDR = '1;
    localparam logic [FIELD_W-1:0] SA_MODE_LO = '0;
    localparam logic [FIELD_W-1:0] SA_MODE_HI = '1;
    localparam logic [FIELD_W-1:0] MC_TX_STAT = FIELD_W'(2);
    localparam logic [FIELD_W-1:0] MC_TX_LAST = FIELD_W'(18);
    localparam logic [WORD_W-1:0]  HOST_STAT_MASK = 16'h03EF;
    localparam int ME_BIT  = 10;
    localparam int BCR_BIT = 4;

    typedef struct packed {
        logic [RA_W-1:0]    rt;
        logic               tr;
        logic [FIELD_W-1:0] sa;
        logic [FIELD_W-1:0] wc;
    } cmd_t;

    typedef logic [LEG_REGS-1:0][WORD_W-1:0] leg_bank_t;
endpackage

// File: rtl/rtls_regbank.sv
module rtls_regbank
    import rtls_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HA_W-1:0]    host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    input  logic               clear_req,
    output leg_bank_t          leg,
    output logic [RA_W-1:0]    rt_addr,
    output logic               rt_par,
    output logic               bcast_en,
    output logic               ice,
    output logic [WORD_W-1:0]  hstat,
    output logic [WORD_W-1:0]  rdata
);
    typedef struct packed {
        leg_bank_t         leg;
        logic [WORD_W-1:0] hstat;
        logic              ice;
        logic [RA_W-1:0]   rt;
        logic              par;
        logic              ben;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  leg_hit;

    assign leg_hit = host_addr < HA_LEG_END;

    always_comb begin
        bank_d = bank_q;
        if (clear_req) begin
            bank_d.hstat = '0;
        end
        if (host_we) begin
            if (leg_hit) begin
                bank_d.leg[host_addr[REG_SEL_W-1:0]] = host_wdata;
            end else if (host_addr == HA_STATUS) begin
                bank_d.ice   = host_wdata[WORD_W-1];
                bank_d.hstat = host_wdata & HOST_STAT_MASK;
            end else if (host_addr == HA_CONFIG) begin
                bank_d.rt  = host_wdata[WORD_W-1 -: RA_W];
                bank_d.par = host_wdata[WORD_W-1-RA_W];
                bank_d.ben = host_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q     <= '0;
            bank_q.par <= 1'b1;
            bank_q.ben <= 1'b1;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (leg_hit) begin
            rdata = bank_q.leg[host_addr[REG_SEL_W-1:0]];
        end else if (host_addr == HA_STATUS) begin
            rdata = {bank_q.ice, bank_q.hstat[WORD_W-2:0]};
        end else if (host_addr == HA_CONFIG) begin
            rdata = {bank_q.rt, bank_q.par, {(WORD_W-RA_W-2){1'b0}}, bank_q.ben};
        end
    end

    assign leg      = bank_q.leg;
    assign rt_addr  = bank_q.rt;
    assign rt_par   = bank_q.par;
    assign bcast_en = bank_q.ben;
    assign ice      = bank_q.ice;
    assign hstat    = bank_q.hstat;
endmodule

// File: rtl/rtls_decode.sv
module rtls_decode
    import rtls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  leg_bank_t         leg,
    input  logic [RA_W-1:0]   rt_addr,
    input  logic              rt_par,
    input  logic              bcast_en,
    output logic              ev_take,
    output logic              ev_legal,
    output logic              ev_bcast,
    output logic              ev_spare,
    output logic              cfg_err,
    output logic              dec_valid,
    output logic              dec_for_us,
    output logic              dec_bcast,
    output logic              dec_legal,
    output logic              dec_respond,
    output logic              dec_data_en
);
    typedef struct packed {
        logic valid;
        logic for_us;
        logic bcast;
        logic legal;
        logic respond;
        logic data_en;
    } dec_t;

    dec_t                 dec_d, dec_q;
    cmd_t                 cmd;
    logic                 is_bcast, is_own, is_mode, illegal;
    logic [FIELD_W-1:0]   field;
    logic [LEG_IDX_W-1:0] idx;

    assign cmd = cmd_word;

    always_comb begin
        cfg_err  = ~(^{rt_addr, rt_par});
        is_bcast = bcast_en && (cmd.rt == BCAST_ADDR);
        is_own   = !cfg_err && !is_bcast && (cmd.rt == rt_addr);
        is_mode  = (cmd.sa == SA_MODE_LO) || (cmd.sa == SA_MODE_HI);
        field    = is_mode ? cmd.wc : cmd.sa;
        idx      = {is_bcast, cmd.tr, is_mode, field};
        illegal  = leg[idx[LEG_IDX_W-1:BIT_SEL_W]][idx[BIT_SEL_W-1:0]];

        ev_take  = cmd_valid && (is_own || is_bcast);
        ev_legal = !illegal;
        ev_bcast = is_bcast;
        ev_spare = is_mode && cmd.tr && !is_bcast &&
                   ((cmd.wc == MC_TX_STAT) || (cmd.wc == MC_TX_LAST));

        dec_d         = '0;
        dec_d.valid   = cmd_valid;
        dec_d.for_us  = ev_take;
        dec_d.bcast   = ev_take && is_bcast;
        dec_d.legal   = ev_take && !illegal;
        dec_d.respond = ev_take && !is_bcast;
        dec_d.data_en = ev_take && !illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid   = dec_q.valid;
    assign dec_for_us  = dec_q.for_us;
    assign dec_bcast   = dec_q.bcast;
    assign dec_legal   = dec_q.legal;
    assign dec_respond = dec_q.respond;
    assign dec_data_en = dec_q.data_en;
endmodule

// File: rtl/rtls_status.sv
module rtls_status
    import rtls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_take,
    input  logic              ev_legal,
    input  logic              ev_bcast,
    input  logic              ev_spare,
    input  logic              stat_sent,
    input  logic              ice,
    input  logic [WORD_W-1:0] hstat,
    input  logic [RA_W-1:0]   rt_addr,
    output logic              clear_req,
    output logic [WORD_W-1:0] status_word
);
    typedef struct packed {
        logic me;
        logic bcr;
        logic spare;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_take) begin
            st_d.spare = ev_spare && ev_legal;
            if (!(ev_spare && ev_legal)) begin
                st_d.me  = !ev_legal;
                st_d.bcr = ev_bcast && ev_legal;
            end
        end
        clear_req = stat_sent && ice && !st_q.spare;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_word = hstat & HOST_STAT_MASK;
        status_word[WORD_W-1 -: RA_W] = rt_addr;
        status_word[ME_BIT]  = st_q.me;
        status_word[BCR_BIT] = st_q.bcr;
    end
endmodule

// File: rtl/rt_legal_status.sv
module rt_legal_status
    import rtls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              stat_sent,
    output logic              dec_valid,
    output logic              dec_for_us,
    output logic              dec_bcast,
    output logic              dec_legal,
    output logic              dec_respond,
    output logic              dec_data_en,
    output logic [WORD_W-1:0] status_word,
    output logic              cfg_err
);
    leg_bank_t         leg;
    logic [RA_W-1:0]   rt_addr;
    logic              rt_par, bcast_en, ice, clear_req;
    logic [WORD_W-1:0] hstat;
    logic              ev_take, ev_legal, ev_bcast, ev_spare;

    rtls_regbank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .clear_req  (clear_req),
        .leg        (leg),
        .rt_addr    (rt_addr),
        .rt_par     (rt_par),
        .bcast_en   (bcast_en),
        .ice        (ice),
        .hstat      (hstat),
        .rdata      (host_rdata)
    );

    rtls_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .leg         (leg),
        .rt_addr     (rt_addr),
        .rt_par      (rt_par),
        .bcast_en    (bcast_en),
        .ev_take     (ev_take),
        .ev_legal    (ev_legal),
        .ev_bcast    (ev_bcast),
        .ev_spare    (ev_spare),
        .cfg_err     (cfg_err),
        .dec_valid   (dec_valid),
        .dec_for_us  (dec_for_us),
        .dec_bcast   (dec_bcast),
        .dec_legal   (dec_legal),
        .dec_respond (dec_respond),
        .dec_data_en (dec_data_en)
    );

    rtls_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_take     (ev_take),
        .ev_legal    (ev_legal),
        .ev_bcast    (ev_bcast),
        .ev_spare    (ev_spare),
        .stat_sent   (stat_sent),
        .ice         (ice),
        .hstat       (hstat),
        .rt_addr     (rt_addr),
        .clear_req   (clear_req),
        .status_word (status_word)
    );
endmodule

// File: rtl/rtls_checker.sv
module rtls_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic        cmd_valid,
    input logic        dec_valid,
    input logic        dec_for_us,
    input logic        dec_bcast,
    input logic        dec_legal,
    input logic        dec_respond,
    input logic        dec_data_en,
    input logic [15:0] status_word,
    input logic        cfg_err
);
    assert_illegal_sets_me_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_for_us && !dec_legal |-> status_word[10]);

    assert_data_needs_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_data_en |-> dec_legal && dec_for_us);

    assert_bcast_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_bcast && dec_legal |-> status_word[4] && !dec_respond);

    assert_cfgerr_mutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && $past(cfg_err) |-> !(dec_for_us && !dec_bcast));

    assert_addr_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_we) |-> $stable(status_word[15:11]));

    assert_foreign_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_for_us |-> !dec_respond && !dec_data_en &&
            $stable(status_word[10]) && $stable(status_word[4]));

    assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(cmd_valid));
endmodule

bind rt_legal_status rtls_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .cmd_valid   (cmd_valid),
    .dec_valid   (dec_valid),
    .dec_for_us  (dec_for_us),
    .dec_bcast   (dec_bcast),
    .dec_legal   (dec_legal),
    .dec_respond (dec_respond),
    .dec_data_en (dec_data_en),
    .status_word (status_word),
    .cfg_err     (cfg_err)
);

// File: tb/rt_legal_status_bench.sv
`timescale 1ns/1ps
module rt_legal_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        stat_sent = 1'b0;
    logic        dec_valid, dec_for_us, dec_bcast, dec_legal, dec_respond, dec_data_en;
    logic [15:0] status_word;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rt_legal_status u_rt_legal_status (.*);

    function automatic logic [15:0] mk(input int rt, input int tr, input int sa, input int wc);
        return {rt[4:0], tr[0], sa[4:0], wc[4:0]};
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic sent_pulse();
        @(negedge clk);
        stat_sent = 1'b1;
        @(negedge clk);
        stat_sent = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(5'd17, v); check("R11", "config reset", v, 16'h0401);
        rd(5'd16, v); check("R11", "status ctrl reset", v, 16'h0000);
        rd(5'd0, v);  check("R11", "bitmap reset", v, 16'h0000);
        check("R11", "status word reset", status_word, 16'h0000);
        check("R11", "cfg_err reset", {15'b0, cfg_err}, 16'h0000);
    endtask

    task automatic t_basic();
        wr(5'd17, 16'h2C01);
        check("R7", "address field", status_word, 16'h2800);
        check("R6", "good parity", {15'b0, cfg_err}, 16'h0000);
        send(mk(5, 0, 3, 4));
        check("R12", "valid pulse", {15'b0, dec_valid}, 16'h0001);
        check("R1", "legal rx sa3 flags",
              {10'b0, dec_for_us, dec_bcast, dec_legal, dec_respond, dec_data_en, 1'b0}, 16'h002E);
        @(negedge clk);
        check("R12", "valid drops", {15'b0, dec_valid}, 16'h0000);
    endtask

    task automatic t_illegal();
        wr(5'd0, 16'h0008);
        send(mk(5, 0, 3, 4));
        check("R1", "rx sa3 illegal", {15'b0, dec_legal}, 16'h0000);
        check("R3", "no data on illegal", {15'b0, dec_data_en}, 16'h0000);
        check("R3", "still responds", {15'b0, dec_respond}, 16'h0001);
        check("R3", "ME set", status_word, 16'h2C00);
        send(mk(7, 0, 3, 4));
        check("R10", "foreign ignored", {13'b0, dec_for_us, dec_respond, dec_data_en}, 16'h0000);
        check("R10", "status unchanged", status_word, 16'h2C00);
        wr(5'd0, 16'h0000);
        wr(5'd4, 16'h0008);
        send(mk(5, 1, 3, 5));
        check("R1", "tx sa3 illegal", {15'b0, dec_legal}, 16'h0000);
        send(mk(5, 0, 3, 5));
        check("R1", "rx sa3 legal", {15'b0, dec_legal}, 16'h0001);
        check("R3", "ME cleared", status_word, 16'h2800);
        wr(5'd4, 16'h0000);
        wr(5'd1, 16'h0010);
        send(mk(5, 0, 20, 1));
        check("R1", "rx sa20 illegal", {15'b0, dec_legal}, 16'h0000);
        send(mk(5, 0, 21, 1));
        check("R1", "rx sa21 legal", {15'b0, dec_legal}, 16'h0001);
        wr(5'd1, 16'h0000);
    endtask

    task automatic t_mode();
        wr(5'd3, 16'h0002);
        send(mk(5, 0, 0, 17));
        check("R2", "mode 17 via sa0 illegal", {15'b0, dec_legal}, 16'h0000);
        send(mk(5, 0, 31, 17));
        check("R2", "mode 17 via sa31 illegal", {15'b0, dec_legal}, 16'h0000);
        send(mk(5, 0, 1, 17));
        check("R2", "sa1 not a mode code", {15'b0, dec_legal}, 16'h0001);
        wr(5'd3, 16'h0000);
    endtask

    task automatic t_bcast();
        send(mk(31, 0, 3, 4));
        check("R4", "legal bcast flags",
              {12'b0, dec_for_us, dec_bcast, dec_legal, dec_respond}, 16'h000E);
        check("R4", "BCR set", status_word, 16'h2810);
        wr(5'd8, 16'h0008);
        send(mk(31, 0, 3, 4));
        check("R4", "illegal bcast", {14'b0, dec_legal, dec_respond}, 16'h0000);
        check("R4", "illegal bcast status", status_word, 16'h2C00);
        wr(5'd8, 16'h0000);
        wr(5'd17, 16'hF800);
        check("R6", "parity of 31", {15'b0, cfg_err}, 16'h0000);
        send(mk(31, 0, 3, 4));
        check("R5", "31 as own address",
              {13'b0, dec_for_us, dec_bcast, dec_respond}, 16'h0005);
        check("R5", "status for rt31", status_word, 16'hF800);
    endtask

    task automatic t_parity();
        wr(5'd17, 16'h2801);
        check("R6", "bad parity flagged", {15'b0, cfg_err}, 16'h0001);
        send(mk(5, 0, 3, 4));
        check("R6", "own address muted", {14'b0, dec_for_us, dec_respond}, 16'h0000);
        wr(5'd17, 16'h2C01);
        check("R6", "parity restored", {15'b0, cfg_err}, 16'h0000);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        send(mk(5, 0, 3, 4));
        wr(5'd16, 16'h8711);
        rd(5'd16, v); check("R7", "masked host bits", v, 16'h8301);
        check("R7", "status with host bits", status_word, 16'h2B01);
        send(mk(5, 0, 3, 4));
        sent_pulse();
        rd(5'd16, v); check("R8", "immediate clear", v, 16'h8000);
        check("R8", "status after clear", status_word, 16'h2800);
        wr(5'd16, 16'h8301);
        send(mk(5, 1, 0, 2));
        sent_pulse();
        rd(5'd16, v); check("R9", "tx status word spared", v, 16'h8301);
        send(mk(5, 1, 31, 18));
        sent_pulse();
        rd(5'd16, v); check("R9", "tx last command spared", v, 16'h8301);
        send(mk(5, 1, 0, 3));
        sent_pulse();
        rd(5'd16, v); check("R8", "other mode code clears", v, 16'h8000);
        wr(5'd16, 16'h0301);
        send(mk(5, 0, 3, 4));
        sent_pulse();
        rd(5'd16, v); check("R8", "no clear when disabled", v, 16'h0301);
    endtask

    task automatic t_keep_me();
        wr(5'd0, 16'h0008);
        send(mk(5, 0, 3, 4));
        check("R3", "ME set again", status_word, 16'h2F01);
        send(mk(5, 1, 0, 2));
        check("R9", "ME kept by tx status", status_word, 16'h2F01);
        send(mk(5, 0, 4, 4));
        check("R3", "ME cleared by legal", status_word, 16'h2B01);
        wr(5'd0, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_illegal();
        t_mode();
        t_bcast();
        t_parity();
        t_clear();
        t_keep_me();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule